// File: doc/BRIEF.md
# Keyed Windowed Watchdog

This block is a safety timer for a processor subsystem. Its count advances on a separate watchdog clock enable, so it does not depend on the CPU. Once the count runs out, the block raises a fault. A configuration bit decides whether that fault becomes a one-cycle reset request or an interrupt that software must acknowledge. To restart the count, software writes two key bytes to a key register in the right order. Writing the wrong bytes does not restart anything.

The control register refuses a write that does not carry a fixed three-bit check pattern. Such a write is itself treated as a fault. A sticky lock bit keeps the watchdog enabled until the next system reset. An optional window threshold makes a service that arrives too early a fault as well, so a runaway loop that services too often is caught.

The bus is a plain synchronous register port with four word addresses: control (0), key (1), window (2) and status (3). Reads are combinational from the address.

Top module: `keyed_watchdog`

## Requirements
- R1: After reset, the outputs are low and the control register reads 0x0001 (prescale 1, enabled, reset mode, unlocked). The window reads 0 and the count reads 0. The watchdog starts counting at the first clock with `wd_tick` high and `rst_n` high, with no software action.
- R2: A fault from overflow occurs exactly 256 × PREDIV × 2^(p−1) clock edges with `wd_tick` high after reset or after a service edge. Here p is control bits 2:0, and p = 0 behaves like p = 1.
- R3: A key write (address 1, bits 7:0) of 0x55 arms the sequence. A following 0xAA clears the count and the whole prescaler. Any other value disarms the sequence and does not clear the count. An unarmed 0xAA does nothing.
- R4: Control bit 7 selects the fault action. When it is 0, `rst_req_o` is high for exactly one cycle, in the cycle after the faulting edge. When it is 1, `irq_o` rises in that same cycle and `rst_req_o` stays low.
- R5: `irq_o` stays high until status (address 3) is written with bit 0 set. Writing 0 to that bit has no effect. Status bit 0 reads the interrupt flag.
- R6: A control write whose bits 5:3 are not 3'b101 is discarded as a whole and raises the configured fault. Bits 5:3 always read back as 0.
- R7: Control bit 6 set disables the watchdog. The count (status bits 15:8) then stays 0 and no overflow fault occurs.
- R8: Control bit 8 is set-only and is cleared only by reset. While it is set, the disable bit reads 0 and cannot be set, including in the write that sets the lock.
- R9: If the window (address 2, bits 7:0) is nonzero, a completed key sequence while the count (status bits 15:8) is below the window is a fault and does not restart the count. At or above the window, the service is normal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low system reset |
| wd_tick | input | 1 | Watchdog clock enable, one pulse per watchdog clock |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register word address |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Read data for `addr`, combinational |
| rst_req_o | output | 1 | One-cycle reset request on a fault in reset mode |
| irq_o | output | 1 | Interrupt level on a fault in interrupt mode |

## Verification
Every register write takes effect on the edge that captures it. The same edge registers any fault it causes, so `rst_req_o`, `irq_o` and the read-back value are due in the cycle right after the write. The bench drives on falling edges and samples at the next falling edge. Overflow is due a fixed number of ticking edges after the service or reset edge. The bench counts falling edges from that point until the fault shows and compares the count exactly, so a fault that comes one cycle early or late is caught. The bench runs the divider at 4 instead of 512 to keep timeouts short.

// File: rtl/kwd_pkg.sv
// Shared constants and types for the keyed watchdog.
// Assumes a four-word register map and a 3-bit prescale field.
package kwd_pkg;
    localparam int PSC_W = 3;

    localparam logic [1:0] A_CTRL = 2'd0;
    localparam logic [1:0] A_KEY  = 2'd1;
    localparam logic [1:0] A_WIN  = 2'd2;
    localparam logic [1:0] A_STAT = 2'd3;

    localparam int B_CHK  = 3;
    localparam int B_DIS  = 6;
    localparam int B_IRQ  = 7;
    localparam int B_LOCK = 8;

    localparam logic [2:0] CHK_OK   = 3'b101;
    localparam logic [7:0] KEY_ARM  = 8'h55;
    localparam logic [7:0] KEY_FIRE = 8'hAA;

    typedef struct packed {
        logic             lock;
        logic             irq_sel;
        logic             dis;
        logic [PSC_W-1:0] presc;
    } ctrl_t;

    localparam ctrl_t CTRL_RST = '{lock: 1'b0, irq_sel: 1'b0, dis: 1'b0, presc: 3'd1};
endpackage

// File: rtl/kwd_prescale.sv
// Two-stage tick divider: a fixed divide by PREDIV, then a divide by
// 2^(p-1) selected by the prescale field (p = 0 acts as p = 1).
// Assumes clr restarts both stages so a timeout is exact from that edge.
module kwd_prescale
    import kwd_pkg::*;
#(
    parameter int PREDIV = 512
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             tick,
    input  logic [PSC_W-1:0] presc,
    output logic             step_o
);
    localparam int EXT_W = (1 << PSC_W) - 2;

    logic             coarse;
    logic [PSC_W-1:0] p_eff;
    logic [EXT_W:0]   span;
    logic [EXT_W-1:0] ext_lim;
    logic [EXT_W-1:0] ext_q;

    generate
        if (PREDIV <= 1) begin : g_nodiv
            assign coarse = tick;
        end else begin : g_div
            localparam int DIV_W = $clog2(PREDIV);
            localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(PREDIV - 1);
            logic [DIV_W-1:0] div_q;

            // First stage: count ticks up to PREDIV
            always_ff @(posedge clk) begin
                if (!rst_n || clr)
                    div_q <= '0;
                else if (tick)
                    div_q <= (div_q == DIV_LAST) ? '0 : div_q + 1'b1;
            end

            assign coarse = tick && (div_q == DIV_LAST);
        end
    endgenerate

    // Second-stage limit from the prescale field
    always_comb begin
        p_eff   = (presc == '0) ? PSC_W'(1) : presc;
        span    = (EXT_W+1)'(1) << (p_eff - PSC_W'(1));
        ext_lim = EXT_W'(span - (EXT_W+1)'(1));
    end

    assign step_o = coarse && (ext_q >= ext_lim);

    // Second stage: count coarse pulses up to the selected limit
    always_ff @(posedge clk) begin
        if (!rst_n || clr)
            ext_q <= '0;
        else if (coarse)
            ext_q <= step_o ? '0 : ext_q + 1'b1;
    end
endmodule

// File: rtl/kwd_keyseq.sv
// Two-byte service sequence detector. An arm byte sets the armed flag.
// A fire byte while armed completes a service. Any other byte disarms.
// Assumes key_wr is a single-cycle strobe per bus write.
module kwd_keyseq
    import kwd_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       key_wr,
    input  logic [7:0] key,
    output logic       fire_o,
    output logic       armed_o
);
    logic armed_q;

    assign fire_o  = key_wr && armed_q && (key == KEY_FIRE);
    assign armed_o = armed_q;

    // Track the arm state across key writes
    always_ff @(posedge clk) begin
        if (!rst_n)
            armed_q <= 1'b0;
        else if (key_wr)
            armed_q <= (key == KEY_ARM);
    end
endmodule

// File: rtl/kwd_regs.sv
// Control, window and interrupt-flag registers. A control write must
// carry the check pattern or it is dropped and flagged. The lock bit is
// set-only and forces the disable bit low.
// Assumes CNT_W <= 9 so the window fits the forwarded write bits.
module kwd_regs
    import kwd_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [1:0]       addr,
    input  logic [8:0]       wfield,
    input  logic             set_irq,
    output ctrl_t            ctrl_o,
    output logic [CNT_W-1:0] win_o,
    output logic             irq_o,
    output logic             bad_chk_o
);
    logic ctrl_wr;
    logic win_wr;
    logic stat_wr;
    logic lock_next;

    // Decode writes and the check pattern
    always_comb begin
        ctrl_wr   = wr_en && (addr == A_CTRL);
        win_wr    = wr_en && (addr == A_WIN);
        stat_wr   = wr_en && (addr == A_STAT);
        bad_chk_o = ctrl_wr && (wfield[B_CHK +: 3] != CHK_OK);
        lock_next = ctrl_o.lock | wfield[B_LOCK];
    end

    // Control register, accepted only with a good check pattern
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_o <= CTRL_RST;
        end else if (ctrl_wr && !bad_chk_o) begin
            ctrl_o.presc   <= wfield[PSC_W-1:0];
            ctrl_o.irq_sel <= wfield[B_IRQ];
            ctrl_o.lock    <= lock_next;
            ctrl_o.dis     <= wfield[B_DIS] & ~lock_next;
        end
    end

    // Window threshold register
    always_ff @(posedge clk) begin
        if (!rst_n)
            win_o <= '0;
        else if (win_wr)
            win_o <= wfield[CNT_W-1:0];
    end

    // Interrupt flag: a set wins over a write-one clear
    always_ff @(posedge clk) begin
        if (!rst_n)
            irq_o <= 1'b0;
        else if (set_irq)
            irq_o <= 1'b1;
        else if (stat_wr && wfield[0])
            irq_o <= 1'b0;
    end
endmodule

// File: rtl/keyed_watchdog.sv
// Keyed windowed watchdog top. Holds the timeout counter, merges the
// fault sources (overflow, bad check pattern, early service) and
// drives the reset pulse or the interrupt flag. Assumes DATA_W >= 16
// and CNT_W <= 8 so the status layout fits.
module keyed_watchdog
    import kwd_pkg::*;
#(
    parameter int PREDIV = 512,
    parameter int CNT_W  = 8,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wd_tick,
    input  logic              wr_en,
    input  logic [1:0]        addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              rst_req_o,
    output logic              irq_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;
    localparam int STAT_CNT_LSB = 8;

    ctrl_t            ctrl_q;
    logic [CNT_W-1:0] win_q;
    logic [CNT_W-1:0] cnt_q;
    logic             bad_chk;
    logic             fire;
    logic             armed;
    logic             step;
    logic             key_wr;
    logic             early;
    logic             svc_ok;
    logic             ovf;
    logic             fault;
    logic             set_irq;
    logic             psc_clr;
    logic             wdata_unused;

    assign wdata_unused = ^wdata[DATA_W-1:9];
    assign key_wr       = wr_en && (addr == A_KEY);

    kwd_regs #(.CNT_W(CNT_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .addr      (addr),
        .wfield    (wdata[8:0]),
        .set_irq   (set_irq),
        .ctrl_o    (ctrl_q),
        .win_o     (win_q),
        .irq_o     (irq_o),
        .bad_chk_o (bad_chk)
    );

    kwd_keyseq u_keys (
        .clk     (clk),
        .rst_n   (rst_n),
        .key_wr  (key_wr),
        .key     (wdata[7:0]),
        .fire_o  (fire),
        .armed_o (armed)
    );

    kwd_prescale #(.PREDIV(PREDIV)) u_psc (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (psc_clr),
        .tick   (wd_tick),
        .presc  (ctrl_q.presc),
        .step_o (step)
    );

    // Classify services and collect the fault sources
    always_comb begin
        early   = fire && !ctrl_q.dis && (win_q != '0) && (cnt_q < win_q);
        svc_ok  = fire && !early;
        ovf     = step && !ctrl_q.dis && !svc_ok && (cnt_q == CNT_MAX);
        fault   = ovf | bad_chk | early;
        set_irq = fault & ctrl_q.irq_sel;
        psc_clr = svc_ok | ctrl_q.dis;
    end

    // Timeout counter: cleared by a service or while disabled, wraps on overflow
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (ctrl_q.dis || svc_ok)
            cnt_q <= '0;
        else if (step)
            cnt_q <= cnt_q + 1'b1;
    end

    // One-cycle reset request for faults in reset mode
    always_ff @(posedge clk) begin
        if (!rst_n)
            rst_req_o <= 1'b0;
        else
            rst_req_o <= fault & ~ctrl_q.irq_sel;
    end

    // Read mux over the four registers
    always_comb begin
        rdata = '0;
        case (addr)
            A_CTRL: begin
                rdata[PSC_W-1:0] = ctrl_q.presc;
                rdata[B_DIS]     = ctrl_q.dis;
                rdata[B_IRQ]     = ctrl_q.irq_sel;
                rdata[B_LOCK]    = ctrl_q.lock;
            end
            A_KEY:  rdata[0] = armed;
            A_WIN:  rdata[CNT_W-1:0] = win_q;
            A_STAT: begin
                rdata[0]                      = irq_o;
                rdata[STAT_CNT_LSB +: CNT_W] = cnt_q;
            end
            default: rdata = '0;
        endcase
    end
endmodule

// File: rtl/keyed_watchdog_chk.sv
// Property checker for the keyed watchdog, bound to the top module.
// Assumes its inputs are sampled on the block's own clock.
module kwd_chk
    import kwd_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_en,
    input logic [1:0]       addr,
    input logic             clr_bit,
    input logic [2:0]       ctrl_rd,
    input logic             rst_req,
    input logic             irq,
    input logic             irq_sel,
    input logic             dis,
    input logic             lock,
    input logic [CNT_W-1:0] cnt
);
    // R4
    rst_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |-> !$past(irq_sel));

    // R4
    irq_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(irq_sel));

    // R5
    irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq) |-> $past(wr_en && (addr == A_STAT) && clr_bit));

    // R7
    dis_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dis && $past(dis)) |-> (cnt == '0));

    // R8
    lock_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(lock) |-> lock);

    // R8
    lock_forces_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lock |-> !dis);

    // R2
    cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cnt) |-> ((cnt == CNT_W'($past(cnt) + 1'b1)) || (cnt == '0)));

    // Check field never reads back
    always_comb begin
        if (addr == A_CTRL) begin
            // R6
            chk_field_zero_chk: assert (ctrl_rd == 3'b000);
        end
    end
endmodule

bind keyed_watchdog kwd_chk #(.CNT_W(CNT_W)) u_kwd_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .addr    (addr),
    .clr_bit (wdata[0]),
    .ctrl_rd (rdata[5:3]),
    .rst_req (rst_req_o),
    .irq     (irq_o),
    .irq_sel (ctrl_q.irq_sel),
    .dis     (ctrl_q.dis),
    .lock    (ctrl_q.lock),
    .cnt     (cnt_q)
);

// File: tb/keyed_watchdog_bench.sv
module keyed_watchdog_bench;
    localparam int PREDIV = 4;
    localparam int CNT_W  = 8;
    localparam int DATA_W = 16;
    localparam int T1     = 256 * PREDIV;
    localparam int NV     = 13;

    // {addr, wdata, expected irq after the write}
    localparam logic [18:0] VEC [NV] = '{
        {2'd1, 16'h0055, 1'b0},
        {2'd1, 16'h00AA, 1'b1},
        {2'd3, 16'h0001, 1'b0},
        {2'd1, 16'h00AA, 1'b0},
        {2'd1, 16'h0055, 1'b0},
        {2'd1, 16'h0012, 1'b0},
        {2'd1, 16'h00AA, 1'b0},
        {2'd1, 16'h0055, 1'b0},
        {2'd1, 16'h0055, 1'b0},
        {2'd1, 16'h00AA, 1'b1},
        {2'd3, 16'h0001, 1'b0},
        {2'd0, 16'h0058, 1'b1},
        {2'd3, 16'h0001, 1'b0}
    };

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              wd_tick = 1'b0;
    logic              wr_en = 1'b0;
    logic [1:0]        addr = 2'd0;
    logic [DATA_W-1:0] wdata = '0;
    logic [DATA_W-1:0] rdata;
    logic              rst_req_o;
    logic              irq_o;
    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    keyed_watchdog #(.PREDIV(PREDIV), .CNT_W(CNT_W), .DATA_W(DATA_W)) u_keyed_watchdog (
        .clk(clk), .rst_n(rst_n), .wd_tick(wd_tick), .wr_en(wr_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .rst_req_o(rst_req_o), .irq_o(irq_o)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp, input string what);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [15:0] d);
        addr = a;
        #1;
        d = rdata;
    endtask

    task automatic service();
        wr(2'd1, 16'h0055);
        wr(2'd1, 16'h00AA);
    endtask

    task automatic time_to_fault(input int lim, output int n);
        n = 0;
        while (!(rst_req_o || irq_o) && n < lim) begin
            @(negedge clk);
            n++;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL R1 watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int n;
        int seen;
        logic [15:0] d;

        // R1: reset state
        repeat (3) @(negedge clk);
        check("R1", rst_req_o, 0, "rst_req in reset");
        check("R1", irq_o, 0, "irq in reset");
        rd(2'd0, d); check("R1", d, 16'h0001, "ctrl reset value");
        rd(2'd2, d); check("R1", d, 16'h0000, "window reset value");
        rd(2'd3, d); check("R1", d, 16'h0000, "status reset value");

        // R1/R2: counts from reset with no software action
        rst_n = 1'b1; wd_tick = 1'b1;
        time_to_fault(20000, n);
        check("R2", n, T1, "cycles reset to overflow");
        check("R4", irq_o, 0, "irq stays low in reset mode");
        @(negedge clk);
        check("R4", rst_req_o, 0, "reset pulse one cycle wide");

        // R3: service restarts the full timeout
        service();
        time_to_fault(20000, n);
        check("R3", n, T1, "cycles service to overflow");

        // R2: prescale 3 and prescale 0
        wr(2'd0, 16'h002B);
        service();
        time_to_fault(20000, n);
        check("R2", n, 4 * T1, "timeout with p=3");
        wr(2'd0, 16'h0028);
        service();
        time_to_fault(20000, n);
        check("R2", n, T1, "timeout with p=0");

        // R7: disabled watchdog does not count
        wr(2'd0, 16'h0069);
        rd(2'd0, d); check("R7", d, 16'h0041, "ctrl with disable");
        seen = 0;
        for (int i = 0; i < 3000; i++) begin
            @(negedge clk);
            if (rst_req_o) seen++;
        end
        check("R7", seen, 0, "faults while disabled");
        rd(2'd3, d); check("R7", d[15:8], 0, "count while disabled");

        // R8: lock forces enable and is sticky
        wr(2'd0, 16'h0169);
        rd(2'd0, d); check("R8", d, 16'h0101, "lock and disable in one write");
        wr(2'd0, 16'h0069);
        rd(2'd0, d); check("R8", d, 16'h0101, "disable ignored when locked");
        wr(2'd0, 16'h0029);
        rd(2'd0, d); check("R8", d, 16'h0101, "lock not clearable");
        repeat (20) @(negedge clk);
        rd(2'd3, d); check("R8", d[15:8] != 0, 1, "count runs when locked");

        // R9: window violation and a legal late service
        service();
        check("R9", rst_req_o, 0, "service with window off");
        wr(2'd2, 16'h0040);
        repeat (10) @(negedge clk);
        service();
        check("R9", rst_req_o, 1, "early service fault");
        rd(2'd3, d); check("R9", d[15:8] != 0, 1, "early service keeps count");
        n = 0;
        d = 16'h0000;
        while (d[15:8] < 8'h41 && n < 2000) begin
            @(negedge clk);
            rd(2'd3, d);
            n++;
        end
        service();
        check("R9", rst_req_o, 0, "service after window");
        rd(2'd3, d); check("R9", d[15:8], 0, "count cleared by late service");

        // Table run in interrupt mode with the count frozen at 0
        rst_n = 1'b0; wd_tick = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        rd(2'd0, d); check("R8", d, 16'h0001, "reset clears lock");
        wr(2'd0, 16'h00A9);
        wr(2'd2, 16'h0001);
        for (int i = 0; i < NV; i++) begin
            wr(VEC[i][18:17], VEC[i][16:1]);
            if (VEC[i][18:17] == 2'd1)
                check("R3", irq_o, VEC[i][0], $sformatf("key row %0d", i));
            else if (VEC[i][18:17] == 2'd0)
                check("R6", irq_o, VEC[i][0], $sformatf("bad check row %0d", i));
            else
                check("R5", irq_o, VEC[i][0], $sformatf("clear row %0d", i));
            check("R4", rst_req_o, 0, $sformatf("no reset pulse row %0d", i));
        end
        rd(2'd0, d); check("R6", d, 16'h0081, "bad control write discarded");

        // R4/R5: overflow in interrupt mode and flag clearing
        wr(2'd2, 16'h0000);
        @(negedge clk);
        wd_tick = 1'b1;
        time_to_fault(20000, n);
        check("R4", n, T1, "cycles to interrupt overflow");
        check("R4", rst_req_o, 0, "no reset pulse in interrupt mode");
        repeat (5) @(negedge clk);
        check("R5", irq_o, 1, "interrupt level held");
        wr(2'd3, 16'h0000);
        check("R5", irq_o, 1, "zero write leaves flag");
        rd(2'd3, d); check("R5", d[0], 1, "status flag bit");
        wr(2'd3, 16'h0001);
        check("R5", irq_o, 0, "write-one clears flag");

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule